// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores one complete received frame into host memory through a ring of 8-byte receive descriptors. When a frame is offered, the block first walks the ring from its current position and confirms that enough empty buffers exist to hold the whole frame. Only then does it write anything. It then copies the payload into the buffers, followed by a 4-byte CRC-32. It writes back each descriptor's length and status, and it advances the ring pointer. After the frame it reads the next descriptor and decides whether reception stays armed.

Each descriptor is two big-endian 32-bit words. The first word holds a 16-bit status halfword in bits 31:16 and a 16-bit byte count in bits 15:0. The second word is the buffer's byte address. Data is written one byte per cycle through a 32-bit memory port that uses byte enables. The payload is fetched from an indexed frame store, where the byte index is presented and the byte returns in the same cycle.

The states are `S_IDLE`, `S_ARM`, `S_CHECK`, `S_HEAD`, `S_PTR`, `S_DATA` and `S_CLOSE`. These are the transitions:
- In idle, a frame start goes to check if reception is armed. Otherwise the frame is dropped.
- In idle, an activation goes to arm.
- Arm goes back to idle.
- Check loops on itself over the ring. It goes to head when the frame fits and back to idle when the frame is refused.
- Head goes to pointer, and pointer goes to data.
- Data goes to close after the last byte of the buffer.
- Close goes to head for the next buffer, or to arm after the final buffer.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `rx_active`, `busy`, `frm_done`, `ev_rx_buf` and `ev_rx_frame` are all 0. The buffer size is 0x7F0 and the length limit is 0x05EE.
- R2: A frame offered while `rx_active` is 0 completes with `frm_done`=1 and `frm_stored`=0, and it leaves memory untouched.
- R3: The stored size is the payload length plus 4. The payload bytes come first. Immediately after them comes the CRC-32, most significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, is inverted at the end, and covers the stored payload bytes. The CRC may straddle two buffers.
- R4: Before any write, the ring is walked from the current pointer. Each descriptor covers one buffer size. If a descriptor whose empty bit (status bit 15, word bit 31) is clear is reached before the size is covered, the frame is refused: `frm_stored`=0, memory and `rx_active` are unchanged, and the pointer does not move.
- R5: Each descriptor receives min(remaining, buffer size) bytes. Its count field is set to that number and its empty bit is cleared. Its other status bits are kept.
- R6: The final descriptor also gets the last bit (status bit 11) ORed with the error bits, and it pulses `ev_rx_frame`. Every earlier descriptor pulses `ev_rx_buf`. The two pulses never occur together.
- R7: A stored size above 2032 is cut to 2032. The CRC lands in the last 4 of those bytes. Both status bit 0 (truncated) and status bit 5 (too long) are set.
- R8: Status bit 5 is also set when the stored size exceeds the length limit. The limit is written with `cfg_sel`=2 from `cfg_wdata[15:0]`.
- R9: A write with `cfg_sel`=1 sets the buffer size to `cfg_wdata[10:4]`×16. If that field is zero, the size is 0x7F0.
- R10: A write with `cfg_sel`=0 sets the ring base to `cfg_wdata` with bits 1:0 cleared, and it moves the current pointer there. After each descriptor is used, the pointer returns to the base if the descriptor's wrap bit (status bit 13) is set, and otherwise advances by 8.
- R11: After a frame, `rx_active` equals the empty bit of the next descriptor. An `activate` pulse re-reads that bit, but only when `enable` is 1 and `rx_active` is 0.
- R12: While `enable` is 0, `rx_active` is cleared on the next edge, and `activate` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enabled |
| activate | input | 1 | Receive activation pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 ring base, 1 buffer size, 2 length limit |
| cfg_wdata | input | 32 | Configuration write data |
| frm_start | input | 1 | Frame offered (one cycle) |
| frm_len | input | 16 | Payload length in bytes |
| frm_idx | output | 12 | Payload byte index requested |
| frm_byte | input | 8 | Payload byte at `frm_idx` |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables, bit 3 is byte 0 of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for the word at `mem_addr`, valid in the same cycle |
| rx_active | output | 1 | Reception armed |
| busy | output | 1 | Not idle |
| ev_rx_buf | output | 1 | A non-final buffer was closed |
| ev_rx_frame | output | 1 | The final buffer of a frame was closed |
| frm_done | output | 1 | Frame handling finished (one cycle) |
| frm_stored | output | 1 | Frame was stored, valid with `frm_done` |

## Verification
A dropped frame reports `frm_done` one edge after the start edge. An activation updates `rx_active` two edges after the pulse is first sampled. A stored frame costs one cycle per descriptor walked, then three cycles plus the byte count per buffer, and one re-arm read. The bench therefore samples every result on the falling edge: it waits for `frm_done` and accumulates the event pulses on each falling edge up to that point. Memory contents are compared only after `frm_done`, and `rx_active` is read on the same edge as `frm_done`. Expected descriptor words, byte streams and CRCs are derived arithmetically from the length, seed, buffer size and ring layout over a sweep of 44 payload lengths.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int MAX_FRAME  = 2032;
    localparam int CRC_LEN    = 4;
    localparam int DESC_STEP  = 8;
    localparam int F_EMPTY    = 15;
    localparam int F_WRAP     = 13;
    localparam int F_LAST     = 11;
    localparam int F_LONG     = 5;
    localparam int F_TRUNC    = 0;
    localparam logic [10:0] BUF_MAX    = 11'h7F0;
    localparam logic [15:0] MAXLEN_RST = 16'h05EE;

    typedef enum logic [2:0] {
        S_IDLE, S_ARM, S_CHECK, S_HEAD, S_PTR, S_DATA, S_CLOSE
    } rxw_state_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rxw_cfg.sv
module rxw_cfg
    import rxw_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 11,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [AW-1:0] ring_base,
    output logic [BW-1:0] buf_size,
    output logic [LW-1:0] max_len
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_base <= '0;
            buf_size  <= BW'(BUF_MAX);
            max_len   <= LW'(MAXLEN_RST);
        end else if (cfg_we) begin
            case (cfg_sel)
                2'd0: ring_base <= {cfg_wdata[AW-1:2], 2'b00};
                2'd1: buf_size  <= (cfg_wdata[BW-1:4] == '0) ? BW'(BUF_MAX)
                                                             : {cfg_wdata[BW-1:4], 4'b0000};
                2'd2: max_len   <= cfg_wdata[LW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxw_crc.sv
module rxw_crc
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        shift,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    logic [31:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '1;
        else if (clear) acc <= '1;
        else if (shift) acc <= crc_step(acc, din);
    end

    assign crc_out = ~acc;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int BW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        activate,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        frm_start,
    input  logic [15:0] frm_len,
    output logic [11:0] frm_idx,
    input  logic [7:0]  frm_byte,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        rx_active,
    output logic        busy,
    output logic        ev_rx_buf,
    output logic        ev_rx_frame,
    output logic        frm_done,
    output logic        frm_stored
);
    localparam int SW = $clog2(MAX_FRAME) + 1;
    localparam int XW = LW + 1;

    rxw_state_e state, state_nx;
    logic [AW-1:0] cur_ptr, walk_ptr, buf_addr, byte_addr;
    logic [SW-1:0] remain, left, kidx, pay_n, chunk, cnt, bsz, chunk_nx, crc_off, new_sz;
    logic [15:0]   flags_q, err_q, new_err, close_flags;
    logic          arm_post, is_pay, last_blk, trunc, too_long;
    logic [XW-1:0] raw_sz;
    logic [AW-1:0] ring_base;
    logic [BW-1:0] buf_size;
    logic [LW-1:0] max_len;
    logic [31:0]   crc_val;
    logic [7:0]    wbyte;
    logic          crc_shift;

    rxw_cfg #(.AW(AW), .BW(BW), .LW(LW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ring_base(ring_base), .buf_size(buf_size), .max_len(max_len)
    );

    rxw_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE && frm_start),
        .shift(crc_shift), .din(frm_byte), .crc_out(crc_val)
    );

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic w);
        return w ? ring_base : p + AW'(DESC_STEP);
    endfunction

    // Frame sizing
    assign raw_sz   = {1'b0, frm_len} + XW'(CRC_LEN);
    assign trunc    = raw_sz > XW'(MAX_FRAME);
    assign new_sz   = trunc ? SW'(MAX_FRAME) : raw_sz[SW-1:0];
    assign too_long = LW'(new_sz) > max_len;
    always_comb begin
        new_err          = '0;
        new_err[F_TRUNC] = trunc;
        new_err[F_LONG]  = trunc | too_long;
    end

    // Byte path
    assign bsz       = SW'(buf_size);
    assign chunk_nx  = (left < bsz) ? left : bsz;
    assign is_pay    = kidx < pay_n;
    assign crc_off   = kidx - pay_n;
    assign byte_addr = buf_addr + AW'(cnt);
    assign last_blk  = (left == '0);
    assign frm_idx   = 12'(kidx);
    assign busy      = (state != S_IDLE);

    always_comb begin
        unique case (crc_off[1:0])
            2'd0: wbyte = is_pay ? frm_byte : crc_val[31:24];
            2'd1: wbyte = is_pay ? frm_byte : crc_val[23:16];
            2'd2: wbyte = is_pay ? frm_byte : crc_val[15:8];
            default: wbyte = is_pay ? frm_byte : crc_val[7:0];
        endcase
    end

    always_comb begin
        close_flags          = flags_q;
        close_flags[F_EMPTY] = 1'b0;
        if (last_blk) close_flags = close_flags | err_q | (16'h1 << F_LAST);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state and memory port
    always_comb begin
        state_nx  = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        crc_shift = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (frm_start) begin
                    if (rx_active) state_nx = S_CHECK;
                end else if (activate && enable && !rx_active) begin
                    state_nx = S_ARM;
                end
            end
            S_ARM: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr;
                state_nx = S_IDLE;
            end
            S_CHECK: begin
                mem_req  = 1'b1;
                mem_addr = walk_ptr;
                if (!mem_rdata[16+F_EMPTY]) state_nx = S_IDLE;
                else if (remain <= bsz)     state_nx = S_HEAD;
            end
            S_HEAD: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr;
                state_nx = S_PTR;
            end
            S_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(4);
                state_nx = S_DATA;
            end
            S_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_be    = 4'b1000 >> byte_addr[1:0];
                mem_wdata = {4{wbyte}};
                crc_shift = is_pay;
                if (cnt == chunk - SW'(1)) state_nx = S_CLOSE;
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr;
                mem_be    = 4'b1111;
                mem_wdata = {close_flags, 16'(chunk)};
                state_nx  = last_blk ? S_ARM : S_HEAD;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr <= '0; walk_ptr <= '0; buf_addr <= '0;
            remain <= '0; left <= '0; kidx <= '0; pay_n <= '0; chunk <= '0; cnt <= '0;
            flags_q <= '0; err_q <= '0; arm_post <= 1'b0; rx_active <= 1'b0;
            frm_done <= 1'b0; frm_stored <= 1'b0; ev_rx_buf <= 1'b0; ev_rx_frame <= 1'b0;
        end else begin
            frm_done    <= 1'b0;
            frm_stored  <= 1'b0;
            ev_rx_buf   <= 1'b0;
            ev_rx_frame <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (frm_start) begin
                        if (rx_active) begin
                            remain   <= new_sz;
                            left     <= new_sz;
                            pay_n    <= new_sz - SW'(CRC_LEN);
                            err_q    <= new_err;
                            walk_ptr <= cur_ptr;
                            kidx     <= '0;
                        end else begin
                            frm_done <= 1'b1;
                        end
                    end else if (activate && enable && !rx_active) begin
                        arm_post <= 1'b0;
                    end
                end
                S_ARM: begin
                    rx_active <= mem_rdata[16+F_EMPTY];
                    if (arm_post) begin
                        frm_done   <= 1'b1;
                        frm_stored <= 1'b1;
                    end
                end
                S_CHECK: begin
                    if (!mem_rdata[16+F_EMPTY]) begin
                        frm_done <= 1'b1;
                    end else if (remain > bsz) begin
                        remain   <= remain - bsz;
                        walk_ptr <= step_ptr(walk_ptr, mem_rdata[16+F_WRAP]);
                    end
                end
                S_HEAD: begin
                    flags_q <= mem_rdata[31:16];
                    chunk   <= chunk_nx;
                end
                S_PTR: begin
                    buf_addr <= mem_rdata[AW-1:0];
                    cnt      <= '0;
                end
                S_DATA: begin
                    cnt  <= cnt + SW'(1);
                    kidx <= kidx + SW'(1);
                    left <= left - SW'(1);
                end
                S_CLOSE: begin
                    cur_ptr     <= step_ptr(cur_ptr, flags_q[F_WRAP]);
                    ev_rx_frame <= last_blk;
                    ev_rx_buf   <= !last_blk;
                    arm_post    <= 1'b1;
                end
                default: ;
            endcase
            if (cfg_we && cfg_sel == 2'd0) cur_ptr <= {cfg_wdata[AW-1:2], 2'b00};
            if (!enable) rx_active <= 1'b0;
        end
    end

    // R6
    ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ev_rx_buf && ev_rx_frame));
    // R5
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_DATA) |-> (cnt < chunk));
    // R12
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !rx_active);
    // R11
    rearm_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_frame |-> (state == S_ARM));
    // R4
    refuse_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_stored) |-> !$past(mem_we));
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, enable, activate, cfg_we, frm_start;
    logic [1:0] cfg_sel;
    logic [31:0] cfg_wdata, mem_addr, mem_wdata, mem_rdata;
    logic [15:0] frm_len;
    logic [11:0] frm_idx;
    logic [7:0] frm_byte;
    logic mem_req, mem_we, rx_active, busy, ev_rx_buf, ev_rx_frame, frm_done, frm_stored;
    logic [3:0] mem_be;
    logic [31:0] mem [0:4095];
    int seed_q = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    function automatic logic [7:0] pay_byte(input int s, input int i);
        return 8'((i * 7 + s * 29 + 5) ^ (i >> 3));
    endfunction

    function automatic logic [31:0] ref_crc(input int s, input int n);
        logic [31:0] c = '1;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, pay_byte(s, i)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] rd_byte(input int a);
        return 8'(mem[a >> 2] >> (8 * (3 - (a & 3))));
    endfunction

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .activate(activate),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frm_start(frm_start), .frm_len(frm_len), .frm_idx(frm_idx), .frm_byte(frm_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_active(rx_active), .busy(busy),
        .ev_rx_buf(ev_rx_buf), .ev_rx_frame(ev_rx_frame), .frm_done(frm_done), .frm_stored(frm_stored)
    );

    assign frm_byte  = pay_byte(seed_q, int'(frm_idx));
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[3-l]) mem[mem_addr[13:2]][31-8*l -: 8] <= mem_wdata[31-8*l -: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_act();
        @(negedge clk); activate = 1'b1;
        @(negedge clk); activate = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic build_ring(input int n, input int bufbase, input int stride);
        for (int i = 0; i < n; i++) begin
            mem[2*i]   = (i == n - 1) ? 32'hA000_0000 : 32'h8000_0000;
            mem[2*i+1] = 32'(bufbase + i * stride);
        end
    endtask

    task automatic arm_ring(input int n, input int bufbase, input int stride);
        build_ring(n, bufbase, stride);
        cfg(2'd0, 32'h0000_0003);
        pulse_act();
    endtask

    task automatic send(input int len, input int s, output bit stored, output int rxb, output int rxf);
        rxb = 0; rxf = 0; stored = 0;
        @(negedge clk); seed_q = s; frm_len = 16'(len); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
        forever begin
            if (ev_rx_buf) rxb++;
            if (ev_rx_frame) rxf++;
            if (frm_done) begin stored = frm_stored; break; end
            @(negedge clk);
        end
    endtask

    task automatic verify(input int len, input int s, input int bsz, input int ring_n, input int first,
                          input int maxl, input int bufbase, input int stride, input bit stored,
                          input int rxb, input int rxf, input string dtag);
        int sz, err, nd, pay_n, off, bad_d, bad_b;
        logic [31:0] crc, expw, actw;
        logic [7:0] eb, ab;
        sz = len + 4; err = 0;
        if (sz > 2032) begin sz = 2032; err = 32'h21; end
        if (sz > maxl) err = err | 32'h20;
        nd = (sz + bsz - 1) / bsz;
        pay_n = sz - 4;
        crc = ref_crc(s, pay_n);
        off = 0; bad_d = 0; bad_b = 0; expw = 0; actw = 0; eb = 0; ab = 0;
        chk(stored == 1'b1, "R4", "frame stored", stored, 1);
        chk(rxf == 1, "R6", "final-buffer pulses", rxf, 1);
        chk(rxb == nd - 1, "R6", "buffer pulses", rxb, nd - 1);
        for (int d = 0; d < nd; d++) begin
            int idx, ln;
            logic [31:0] w;
            idx = (first + d) % ring_n;
            ln = (sz - off < bsz) ? sz - off : bsz;
            w = (idx == ring_n - 1) ? 32'h2000_0000 : 32'h0;
            if (d == nd - 1) w = w | 32'h0800_0000 | (32'(err) << 16);
            w = w | 32'(ln);
            if (mem[2*idx] !== w && bad_d == 0) begin bad_d = 1; expw = w; actw = mem[2*idx]; end
            for (int b = 0; b < ln; b++) begin
                int k;
                logic [7:0] e;
                k = off + b;
                e = (k < pay_n) ? pay_byte(s, k) : 8'(crc >> (8 * (3 - (k - pay_n))));
                if (rd_byte(bufbase + idx * stride + b) !== e && bad_b == 0) begin
                    bad_b = 1; eb = e; ab = rd_byte(bufbase + idx * stride + b);
                end
            end
            off += ln;
        end
        chk(bad_d == 0, dtag, "descriptor word", actw, expw);
        chk(bad_b == 0, "R3", "stored byte", ab, eb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit st;
        int rxb, rxf;
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        rst_n = 1'b0; enable = 1'b0; activate = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0;
        cfg_wdata = 32'h0; frm_start = 1'b0; frm_len = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_active == 0 && busy == 0, "R1", "armed/busy after reset", {rx_active, busy}, 0);
        chk(frm_done == 0 && ev_rx_buf == 0 && ev_rx_frame == 0, "R1", "pulses after reset",
            {frm_done, ev_rx_buf, ev_rx_frame}, 0);

        // R12 activation ignored while disabled
        build_ring(8, 32'h800, 32'h40);
        pulse_act();
        chk(rx_active == 0, "R12", "activate while disabled", rx_active, 0);

        // R2 frame while not armed
        enable = 1'b1;
        send(20, 3, st, rxb, rxf);
        chk(st == 0, "R2", "dropped frame stored flag", st, 0);
        chk(mem[0] == 32'h8000_0000 && rd_byte(32'h800) == 8'h00, "R2", "memory after drop", mem[0], 32'h8000_0000);

        // R3 R5 R6 R9 sweep with 16-byte buffers (0x1F keeps bits 10:4 -> 16)
        cfg(2'd1, 32'h0000_001F);
        for (int len = 1; len <= 44; len++) begin
            arm_ring(8, 32'h800, 32'h40);
            send(len, len, st, rxb, rxf);
            verify(len, len, 16, 8, 0, 1518, 32'h800, 32'h40, st, rxb, rxf, "R5");
            chk(rx_active == 1, "R11", "armed after frame", rx_active, 1);
        end

        // R4 refusal when second descriptor is full
        build_ring(8, 32'h800, 32'h40);
        mem[2] = 32'h0000_0000;
        mem[32'h800 >> 2] = 32'hDEAD_BEEF;
        cfg(2'd0, 32'h0);
        pulse_act();
        send(20, 7, st, rxb, rxf);
        chk(st == 0, "R4", "refused frame stored flag", st, 0);
        chk(mem[0] == 32'h8000_0000, "R4", "descriptor after refusal", mem[0], 32'h8000_0000);
        chk(mem[32'h800 >> 2] == 32'hDEAD_BEEF, "R4", "buffer after refusal", mem[32'h800 >> 2], 32'hDEAD_BEEF);
        chk(rx_active == 1, "R4", "armed after refusal", rx_active, 1);
        send(10, 8, st, rxb, rxf);
        verify(10, 8, 16, 8, 0, 1518, 32'h800, 32'h40, st, rxb, rxf, "R4");

        // R10 R11 wrap and re-arm with a two-entry ring
        arm_ring(2, 32'h800, 32'h40);
        send(8, 100, st, rxb, rxf);
        verify(8, 100, 16, 2, 0, 1518, 32'h800, 32'h40, st, rxb, rxf, "R10");
        send(9, 101, st, rxb, rxf);
        verify(9, 101, 16, 2, 1, 1518, 32'h800, 32'h40, st, rxb, rxf, "R10");
        chk(rx_active == 0, "R11", "disarmed when next is full", rx_active, 0);
        mem[0] = 32'h8000_0000;
        mem[2] = 32'hA000_0000;
        pulse_act();
        chk(rx_active == 1, "R11", "activation re-check", rx_active, 1);
        send(5, 102, st, rxb, rxf);
        verify(5, 102, 16, 2, 0, 1518, 32'h800, 32'h40, st, rxb, rxf, "R10");
        chk(rx_active == 1, "R11", "armed on wrapped empty entry", rx_active, 1);
        mem[2] = 32'h2000_0000;
        pulse_act();
        chk(rx_active == 1, "R11", "activation while armed ignored", rx_active, 1);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk(rx_active == 0, "R12", "disable clears armed", rx_active, 0);
        enable = 1'b1;

        // R8 default limit, R9 zero field selects maximum size
        cfg(2'd1, 32'h0);
        arm_ring(2, 32'h1000, 32'h800);
        send(1514, 200, st, rxb, rxf);
        verify(1514, 200, 2032, 2, 0, 1518, 32'h1000, 32'h800, st, rxb, rxf, "R8");
        arm_ring(2, 32'h1000, 32'h800);
        send(1515, 201, st, rxb, rxf);
        verify(1515, 201, 2032, 2, 0, 1518, 32'h1000, 32'h800, st, rxb, rxf, "R8");

        // R7 truncation, R9 field with only low bits -> maximum
        cfg(2'd1, 32'h0000_0007);
        arm_ring(2, 32'h1000, 32'h800);
        send(2040, 202, st, rxb, rxf);
        verify(2040, 202, 2032, 2, 0, 1518, 32'h1000, 32'h800, st, rxb, rxf, "R7");

        // R9 odd buffer size 0x120
        cfg(2'd1, 32'h0000_012F);
        arm_ring(2, 32'h1000, 32'h800);
        send(300, 203, st, rxb, rxf);
        verify(300, 203, 288, 2, 0, 1518, 32'h1000, 32'h800, st, rxb, rxf, "R9");

        // R8 programmed limit
        cfg(2'd1, 32'h0000_0010);
        cfg(2'd2, 32'd30);
        arm_ring(8, 32'h800, 32'h40);
        send(26, 204, st, rxb, rxf);
        verify(26, 204, 16, 8, 0, 30, 32'h800, 32'h40, st, rxb, rxf, "R8");
        arm_ring(8, 32'h800, 32'h40);
        send(27, 205, st, rxb, rxf);
        verify(27, 205, 16, 8, 0, 30, 32'h800, 32'h40, st, rxb, rxf, "R8");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule